// File: doc/BRIEF.md
# Programmable Odd/Even Clock Divider

This block derives a slower clock from its input clock. The ratio N is an unsigned integer taken from an input bus, which may be set by static sources such as a row of switches. Each output period lasts exactly N input cycles, and the output is high for half of that period. For odd N this half-period is reached by a pair of toggle registers. One toggles on rising input edges and one on falling input edges. Their exclusive-OR forms the output, so the high-to-low transition lands midway through an input cycle.

The ratio is copied into an internal register only at a period boundary, so a change on the bus never cuts a period short. Ratios 0 and 1 make the block pass its input clock straight through. An active-high asynchronous reset forces the output low at once. The first rising input edge after reset release starts a fresh period with the ratio then present on the bus.

Top module: `oddeven_clkdiv`

## Requirements
- R1: For every ratio N from 2 to 2^DIV_W-1 (div_i read as unsigned), the rising edges of clk_o are exactly N clk_i cycles apart.
- R2: For even N, clk_o is high for exactly N/2 clk_i cycles per period, and both of its transitions follow rising edges of clk_i.
- R3: For odd N, clk_o is high for (N-1)/2 clk_i cycles plus one half cycle, and its high-to-low transition follows a falling edge of clk_i.
- R4: Every period starts with clk_o rising on a rising edge of clk_i. clk_o stays high during the first floor(N/2) cycles of the period and low from cycle N-floor(N/2) to the end of the period.
- R5: While the active ratio is 0 or 1, clk_o equals clk_i in both clock phases.
- R6: div_i is taken only at a period boundary. A change in the middle of a period leaves that period at the old length and duty, and the new ratio governs the period that follows.
- R7: While rst_i is high, clk_o is low, and asserting rst_i drives clk_o low without waiting for a clock edge. The first rising clk_i edge after release starts a period, with clk_o going high.
- R8: When a ratio of 2 or more is applied during pass-through, the next rising clk_i edge starts a full period of the new ratio, with clk_o high from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Asynchronous reset, active high |
| div_i | input | DIV_W | Division ratio N, unsigned |
| clk_o | output | 1 | Divided clock |

## Verification
The bench times every rising and falling edge of clk_o against the ratio for all ratios from 2 to 15. A design that left out the falling-edge stage would stretch or shorten odd high times by half a cycle. One that decoded the midpoint wrongly would be off by whole cycles. A ratio change is made in the middle of a long period: a design that loaded the ratio at once would produce a runt or a stretched period. Pass-through is entered and left mid-stream, where a counter left stale would delay the first period. Reset is asserted while clk_o is high to catch a reset that only takes effect on a clock edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Operating mode derived from the ratio held for the current period.
    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_EVEN = 2'd1,
        MODE_ODD  = 2'd2
    } div_mode_e;

    function automatic div_mode_e classify(input logic below_two, input logic lsb);
        if (below_two) begin
            return MODE_PASS;
        end
        return lsb ? MODE_ODD : MODE_EVEN;
    endfunction

endpackage

// File: rtl/clkdiv_ratio_ctrl.sv
module clkdiv_ratio_ctrl
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             fall_tgl_i,
    output logic [DIV_W-1:0] ratio_o,
    output logic [DIV_W-1:0] count_o,
    output logic             rise_tgl_o,
    output logic             running_o,
    output div_mode_e        mode_o
);

    localparam logic [DIV_W-1:0] RATIO_RST = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE       = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic [DIV_W-1:0] cnt;
        logic             rise;
        logic             start;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    div_mode_e        mode;
    logic [DIV_W-1:0] last_cnt;
    logic [DIV_W-1:0] half_m1;
    logic             boundary;

    always_comb begin
        mode     = classify(st_q.ratio < RATIO_RST, st_q.ratio[0]);
        last_cnt = st_q.ratio - ONE;
        half_m1  = (st_q.ratio >> 1) - ONE;
        boundary = st_q.start || (mode == MODE_PASS) || (st_q.cnt == last_cnt);
        st_d     = st_q;
        if (boundary) begin
            // Period boundary: take the new ratio and drive the output high.
            st_d.ratio = div_i;
            st_d.cnt   = '0;
            st_d.rise  = ~fall_tgl_i;
            st_d.start = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
            if ((mode == MODE_EVEN) && (st_q.cnt == half_m1)) begin
                // Even ratio: falling transition on a rising input edge.
                st_d.rise = fall_tgl_i;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q.ratio <= RATIO_RST;
            st_q.cnt   <= '0;
            st_q.rise  <= 1'b0;
            st_q.start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o    = st_q.ratio;
    assign count_o    = st_q.cnt;
    assign rise_tgl_o = st_q.rise;
    assign running_o  = ~st_q.start;
    assign mode_o     = mode;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o != MODE_PASS) |-> (count_o < ratio_o)); // R1

    AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_o != '0) |-> $stable(ratio_o)); // R6

endmodule

// File: rtl/clkdiv_fall_stage.sv
module clkdiv_fall_stage
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  div_mode_e        mode_i,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic [DIV_W-1:0] count_i,
    input  logic             rise_tgl_i,
    output logic             fall_tgl_o
);

    logic             fall_d, fall_q;
    logic [DIV_W-1:0] mid;

    always_comb begin
        // For odd N the midpoint count (N-1)/2 equals N>>1.
        mid    = ratio_i >> 1;
        fall_d = fall_q;
        if ((mode_i == MODE_ODD) && (count_i == mid)) begin
            fall_d = rise_tgl_i;
        end
    end

    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= fall_d;
        end
    end

    assign fall_tgl_o = fall_q;

    AST_FALL_HELD_EVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i != MODE_ODD) |-> $stable(fall_tgl_o)); // R2

    AST_FALL_TRACKS_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mode_i == MODE_ODD) && (count_i == (ratio_i >> 1) + DIV_W'(1)))
            |-> (fall_tgl_o == rise_tgl_i)); // R3

endmodule

// File: rtl/clkdiv_out_sel.sv
module clkdiv_out_sel
    import clkdiv_pkg::*;
(
    input  logic      clk_i,
    input  div_mode_e mode_i,
    input  logic      rise_tgl_i,
    input  logic      fall_tgl_i,
    output logic      clk_o
);

    always_comb begin
        if (mode_i == MODE_PASS) begin
            clk_o = clk_i;
        end else begin
            clk_o = rise_tgl_i ^ fall_tgl_i;
        end
    end

endmodule

// File: rtl/oddeven_clkdiv.sv
module oddeven_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             clk_o
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] count;
    logic             rise_tgl;
    logic             fall_tgl;
    logic             running;
    div_mode_e        mode;

    clkdiv_ratio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .div_i      (div_i),
        .fall_tgl_i (fall_tgl),
        .ratio_o    (ratio),
        .count_o    (count),
        .rise_tgl_o (rise_tgl),
        .running_o  (running),
        .mode_o     (mode)
    );

    clkdiv_fall_stage #(.DIV_W(DIV_W)) u_fall (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mode_i     (mode),
        .ratio_i    (ratio),
        .count_i    (count),
        .rise_tgl_i (rise_tgl),
        .fall_tgl_o (fall_tgl)
    );

    clkdiv_out_sel u_sel (
        .clk_i      (clk_i),
        .mode_i     (mode),
        .rise_tgl_i (rise_tgl),
        .fall_tgl_i (fall_tgl),
        .clk_o      (clk_o)
    );

    AST_HIGH_FIRST_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mode != MODE_PASS) && running && (count < (ratio >> 1))) |-> clk_o); // R4

    AST_LOW_SECOND_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mode != MODE_PASS) && (count >= ratio - (ratio >> 1))) |-> !clk_o); // R4

endmodule

// File: tb/oddeven_clkdiv_tb.sv
`timescale 1ns/1ps
module oddeven_clkdiv_tb;

    localparam int  W     = 4;
    localparam real T_CLK = 4.0;

    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic [W-1:0] div_i = W'(4);
    logic         clk_o;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];

    realtime last_rise = 0.0;
    realtime last_fall = 0.0;
    bit      have_rise = 1'b0;
    logic    fall_lvl  = 1'b0;

    always #(T_CLK/2) clk_i = ~clk_i;

    oddeven_clkdiv #(.DIV_W(W)) u_dut (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .div_i (div_i),
        .clk_o (clk_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // Monitor: measures each completed period and compares with the scoreboard.
    always @(posedge clk_o) begin
        realtime now;
        int      n;
        real     per, hi;
        now = $realtime;
        if (have_rise && exp_q.size() > 0) begin
            n   = exp_q.pop_front();
            per = now - last_rise;
            hi  = last_fall - last_rise;
            check(near(per, n * T_CLK), "R1", $sformatf("period N=%0d", n), per, n * T_CLK);
            check(clk_i == 1'b1, "R4", $sformatf("rise on clk_i rising N=%0d", n),
                  real'(clk_i), 1.0);
            if (n % 2 == 0) begin
                check(near(hi, n * T_CLK / 2), "R2", $sformatf("high time N=%0d", n), hi, n * T_CLK / 2);
                check(fall_lvl == 1'b1, "R2", $sformatf("fall on clk_i rising N=%0d", n),
                      real'(fall_lvl), 1.0);
            end else begin
                check(near(hi, n * T_CLK / 2), "R3", $sformatf("high time N=%0d", n), hi, n * T_CLK / 2);
                check(fall_lvl == 1'b0, "R3", $sformatf("fall on clk_i falling N=%0d", n),
                      real'(fall_lvl), 0.0);
            end
        end
        last_rise = now;
        have_rise = 1'b1;
    end

    always @(negedge clk_o) begin
        last_fall = $realtime;
        fall_lvl  = clk_i;
    end

    task automatic drain(input string req);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(posedge clk_i);
            guard++;
        end
        check(exp_q.size() == 0, req, "scoreboard drained", real'(exp_q.size()), 0.0);
        exp_q.delete();
    endtask

    task automatic run_ratio(input int n, input int reps);
        div_i = W'(n);
        repeat (40) @(posedge clk_i);
        for (int k = 0; k < reps; k++) exp_q.push_back(n);
        drain("R1");
    endtask

    task automatic check_pass(input int n);
        div_i = W'(n);
        repeat (20) @(posedge clk_i);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_i);
            #1;
            check(clk_o == 1'b1, "R5", $sformatf("pass-through high N=%0d", n), real'(clk_o), 1.0);
            @(negedge clk_i);
            #1;
            check(clk_o == 1'b0, "R5", $sformatf("pass-through low N=%0d", n), real'(clk_o), 0.0);
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * T_CLK);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R7: held in reset, output low in both clock phases
        #3;
        check(clk_o == 1'b0, "R7", "low in reset, clk high", real'(clk_o), 0.0);
        #2;
        check(clk_o == 1'b0, "R7", "low in reset, clk low", real'(clk_o), 0.0);
        @(negedge clk_i);
        rst_i = 1'b0;
        #0.5;
        check(clk_o == 1'b0, "R7", "low after release", real'(clk_o), 0.0);
        @(posedge clk_i);
        #1;
        check(clk_o == 1'b1, "R7", "first edge starts period", real'(clk_o), 1.0);
        exp_q.push_back(4);
        exp_q.push_back(4);
        drain("R7");

        // R1, R2, R3 across all ratios
        for (int n = 2; n < 16; n++) run_ratio(n, 3);

        // R6: change the ratio in the middle of a long period
        run_ratio(9, 2);
        @(posedge clk_o);
        repeat (2) @(posedge clk_i);
        #1;
        div_i = W'(3);
        exp_q.push_back(9);
        exp_q.push_back(3);
        exp_q.push_back(3);
        drain("R6");

        // odd to even change in the middle of a period
        run_ratio(7, 2);
        @(posedge clk_o);
        repeat (4) @(posedge clk_i);
        #1;
        div_i = W'(4);
        exp_q.push_back(7);
        exp_q.push_back(4);
        drain("R6");

        // R5: pass-through for 0 and 1
        check_pass(0);
        check_pass(1);

        // R8: leave pass-through mid-cycle
        @(posedge clk_i);
        #1;
        div_i = W'(6);
        @(posedge clk_i);
        #1;
        check(clk_o == 1'b1, "R8", "high at first edge after exit", real'(clk_o), 1.0);
        exp_q.push_back(6);
        exp_q.push_back(6);
        drain("R8");

        // R7: asynchronous reset while the output is high
        div_i = W'(8);
        repeat (40) @(posedge clk_i);
        @(posedge clk_o);
        #1;
        check(clk_o == 1'b1, "R7", "high before reset", real'(clk_o), 1.0);
        rst_i = 1'b1;
        #0.5;
        check(clk_o == 1'b0, "R7", "async reset low", real'(clk_o), 0.0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule